// File: doc/BRIEF.md
# Cache Flush Writeback Sequencer

This block carries out the hardware side of a cache flush request. One start pulse from the interrupt logic begins a walk over every line index of the cache, in ascending order. For each index, the block reads the line's valid and dirty bits from the tag array. A line that is both valid and dirty is first written back through a bus request. Every line then receives exactly one invalidate strobe. When the last index has been handled, the block requests the flush-acknowledge special bus cycle. It reports completion one cycle after that cycle's bus-ready.

The walk tolerates bus interruptions. While backoff is asserted, any writeback in flight is abandoned and later reissued for the same line. Lines that were already written back are not written again. Hold and address-hold only freeze the bus side; the walk resumes where it stopped. An empty write buffer is required before any writeback is issued. While the walk runs, `busy` stays high so that the interrupt recognizer treats the flush as non-interruptible. The cache data path and the detailed bus timing sit outside this block.

Top module: `flush_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `wbReq`, `invStrobe`, `ackReq` and `donePulse` are all low.
- R2: A start pulse while idle begins a walk at index 0 that rises by one up to LINES-1. Each index receives exactly one `invStrobe` per flush, and `lineIdx` names the line being struck.
- R3: A line whose valid bit or dirty bit is 0 gets its `invStrobe` in the first cycle it is presented, with no `wbReq`. A flush of an all-clean cache ends with `donePulse` exactly LINES+2 cycles after the cycle in which the start pulse was sampled, when the acknowledge bus-ready comes at once.
- R4: A line with valid=1 and dirty=1 raises `wbReq` for its index until a cycle with `wbReq` and `busRdy` both high. Exactly one such accepted writeback occurs per dirty line. The line's `invStrobe` comes only after that acceptance.
- R5: While `backoff` is high, `wbReq` is low and `busRdy` has no effect. An abandoned writeback is reissued for the same index after `backoff` falls, and completed lines are not written again.
- R6: While `holdReq` or `addrHold` is high, neither `wbReq` nor `ackReq` is asserted. The walk continues from the same point once both are low.
- R7: While `wbufEmpty` is low, no writeback is requested and the walk waits at the dirty line.
- R8: `ackReq` is asserted only after all LINES invalidate strobes of the current flush. It stays asserted (apart from stalls) until `busRdy`.
- R9: `donePulse` is high for exactly one cycle, in the cycle after the one where `ackReq` and `busRdy` were both high. It occurs once per flush.
- R10: `busy` is high from the cycle after the start pulse through the acknowledge acceptance cycle. A start pulse while `busy` is high is ignored, with no restart of the walk and no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Flush start request from the interrupt recognizer |
| busy | output | 1 | Flush in progress; no other interrupt may be recognized |
| lineIdx | output | $clog2(LINES) | Line index being examined, written back or invalidated |
| lineValid | input | 1 | Valid bit of the line at `lineIdx` |
| lineDirty | input | 1 | Dirty (modified) bit of the line at `lineIdx` |
| invStrobe | output | 1 | Invalidate the line at `lineIdx` this cycle |
| wbReq | output | 1 | Writeback bus request for the line at `lineIdx` |
| ackReq | output | 1 | Flush-acknowledge special bus cycle request |
| busRdy | input | 1 | Bus-ready for the current request |
| backoff | input | 1 | Bus backoff; abandons the current writeback |
| holdReq | input | 1 | Bus hold; pauses bus requests |
| addrHold | input | 1 | Address hold; pauses bus requests |
| wbufEmpty | input | 1 | Write buffer empty; required before a writeback |
| donePulse | output | 1 | One-cycle flush-complete pulse |

## Verification
Faults in the index counter appear on the invalidate strobes within a single cycle. A skipped index, a repeated index or a walk that restarts shows up as an out-of-order or missing `invStrobe`, and as a wrong strobe count per line by the end of the flush. A control state that holds a line for the wrong length of time shows up differently. A dirty line can be invalidated before its bus-ready, or a writeback can be repeated after backoff. Either one is visible in the same cycle as an early strobe or a second accepted `wbReq`. Gating errors put `wbReq` or `ackReq` on the bus in a cycle with a stall input high, so they show at once. Acknowledge or done errors appear within one cycle of the final strobe, or of the acknowledge bus-ready.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SCAN = 3'd1,
    ST_WB   = 3'd2,
    ST_INV  = 3'd3,
    ST_ACK  = 3'd4
  } flushState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic doneSet;
  } flushStrb_t;

endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl
  import flush_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       lineValid,
  input  logic       lineDirty,
  input  logic       lastIdx,
  input  logic       busRdy,
  input  logic       backoff,
  input  logic       holdReq,
  input  logic       addrHold,
  input  logic       wbufEmpty,
  output logic       wbReq,
  output logic       invStrobe,
  output logic       ackReq,
  output logic       busy,
  output flushStrb_t strb
);

  flushState_t stateQ, stateD;
  logic        busStall;
  logic        needWb;

  assign busStall = backoff | holdReq | addrHold;
  assign needWb   = lineValid & lineDirty;
  assign busy     = (stateQ != ST_IDLE);

  always_comb begin
    stateD    = stateQ;
    strb      = '0;
    wbReq     = 1'b0;
    invStrobe = 1'b0;
    ackReq    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          strb.idxClr = 1'b1;
          stateD      = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (needWb) begin
          stateD = ST_WB;
        end else begin
          invStrobe   = 1'b1;
          strb.idxInc = 1'b1;
          stateD      = lastIdx ? ST_ACK : ST_SCAN;
        end
      end
      ST_WB: begin
        wbReq = ~busStall & wbufEmpty;
        if (wbReq && busRdy) stateD = ST_INV;
      end
      ST_INV: begin
        invStrobe   = 1'b1;
        strb.idxInc = 1'b1;
        stateD      = lastIdx ? ST_ACK : ST_SCAN;
      end
      ST_ACK: begin
        ackReq = ~busStall;
        if (ackReq && busRdy) begin
          strb.doneSet = 1'b1;
          stateD       = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R4: a dirty line is struck only after its writeback was accepted
  a_r4_inv_after_rdy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_INV) |-> $past(wbReq && busRdy));

  // R5: an unaccepted or abandoned writeback keeps the same line pending
  a_r5_hold_line: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WB && !(wbReq && busRdy)) |=> (stateQ == ST_WB));

endmodule

// File: rtl/flush_dpath.sv
module flush_dpath
  import flush_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  flushStrb_t               strb,
  output logic [$clog2(LINES)-1:0] lineIdx,
  output logic                     lastIdx,
  output logic                     donePulse
);

  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] idxQ;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strb.doneSet;
      if (strb.idxClr)      idxQ <= '0;
      else if (strb.idxInc) idxQ <= (idxQ == IDX_LAST) ? '0 : idxQ + 1'b1;
    end
  end

  assign lineIdx   = idxQ;
  assign lastIdx   = (idxQ == IDX_LAST);
  assign donePulse = doneQ;

  // R9: completion pulse lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

endmodule

// File: rtl/flush_sequencer.sv
module flush_sequencer
  import flush_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  output logic                     busy,
  output logic [$clog2(LINES)-1:0] lineIdx,
  input  logic                     lineValid,
  input  logic                     lineDirty,
  output logic                     invStrobe,
  output logic                     wbReq,
  output logic                     ackReq,
  input  logic                     busRdy,
  input  logic                     backoff,
  input  logic                     holdReq,
  input  logic                     addrHold,
  input  logic                     wbufEmpty,
  output logic                     donePulse
);

  flushStrb_t strb;
  logic       lastIdx;

  flush_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lineValid  (lineValid),
    .lineDirty  (lineDirty),
    .lastIdx    (lastIdx),
    .busRdy     (busRdy),
    .backoff    (backoff),
    .holdReq    (holdReq),
    .addrHold   (addrHold),
    .wbufEmpty  (wbufEmpty),
    .wbReq      (wbReq),
    .invStrobe  (invStrobe),
    .ackReq     (ackReq),
    .busy       (busy),
    .strb       (strb)
  );

  flush_dpath #(.LINES(LINES)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lineIdx   (lineIdx),
    .lastIdx   (lastIdx),
    .donePulse (donePulse)
  );

  // R2: every walk starts at line 0
  a_r2_walk_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (lineIdx == '0));

  // R9: completion follows the acknowledge bus-ready by one cycle
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(ackReq && busRdy));

  // R10: a start pulse during a flush does not end or restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !ackReq) |=> busy);

endmodule

// File: tb/flush_sequencer_tb_top.sv
module flush_sequencer_tb_top;

  localparam int N   = 16;
  localparam int IW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          busy;
  logic [IW-1:0] lineIdx;
  logic          lineValid, lineDirty;
  logic          invStrobe, wbReq, ackReq, donePulse;
  logic          busRdy = 1'b0;
  logic          backoff = 1'b0;
  logic          holdReq = 1'b0;
  logic          addrHold = 1'b0;
  logic          wbufEmpty = 1'b1;

  bit vArr [N];
  bit dArr [N];

  int testCnt = 0;
  int failCnt = 0;

  // bus agent controls
  int rdyWait = 0;
  int waitCnt = 0;
  int boShots = 0, hdShots = 0, ahShots = 0;
  int boLeft = 0, hdLeft = 0, ahLeft = 0;
  int boFired = 0, hdFired = 0, ahFired = 0;

  // monitor statistics
  int cyc = 0;
  int wbCnt [N];
  int invCnt [N];
  int nextInv = 0;
  int orderErr = 0, invEarly = 0, stallViol = 0, wbViol = 0, ackEarly = 0;
  int doneCnt = 0, doneCyc = 0, ackCyc = 0, startCyc = 0;

  always #10 clk = ~clk;

  assign lineValid = vArr[lineIdx];
  assign lineDirty = dArr[lineIdx];

  flush_sequencer #(.LINES(N)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy),
    .lineIdx(lineIdx), .lineValid(lineValid), .lineDirty(lineDirty),
    .invStrobe(invStrobe), .wbReq(wbReq), .ackReq(ackReq), .busRdy(busRdy),
    .backoff(backoff), .holdReq(holdReq), .addrHold(addrHold),
    .wbufEmpty(wbufEmpty), .donePulse(donePulse)
  );

  // bus agent: stall inputs first, then bus-ready, all in the low phase
  always begin
    @(negedge clk);
    #1;
    backoff  = (boLeft > 0); if (boLeft > 0) boLeft--;
    holdReq  = (hdLeft > 0); if (hdLeft > 0) hdLeft--;
    addrHold = (ahLeft > 0); if (ahLeft > 0) ahLeft--;
    #1;
    if (wbReq || ackReq) begin
      if (waitCnt >= rdyWait) begin busRdy = 1'b1; waitCnt = 0; end
      else begin busRdy = 1'b0; waitCnt++; end
    end else begin
      busRdy = 1'b0; waitCnt = 0;
    end
    if (wbReq && !busRdy && waitCnt == 1) begin
      if (boShots > 0) begin boShots--; boLeft = 3; boFired++; end
      else if (hdShots > 0) begin hdShots--; hdLeft = 2; hdFired++; end
    end
    if (ackReq && !busRdy && waitCnt == 1 && ahShots > 0) begin
      ahShots--; ahLeft = 2; ahFired++;
    end
  end

  // monitor: samples in the middle of the low phase
  always begin
    @(negedge clk);
    #5;
    if (rstN) begin
      if (startPulse && !busy) startCyc = cyc;
      if (wbReq && busRdy) wbCnt[lineIdx]++;
      if (wbReq && (backoff || holdReq || addrHold || !wbufEmpty)) stallViol++;
      if (ackReq && (backoff || holdReq || addrHold)) stallViol++;
      if (wbReq && !(vArr[lineIdx] && dArr[lineIdx])) wbViol++;
      if (invStrobe) begin
        if (int'(lineIdx) != nextInv) orderErr++;
        if (vArr[lineIdx] && dArr[lineIdx] && wbCnt[lineIdx] == 0) invEarly++;
        invCnt[lineIdx]++;
        nextInv++;
      end
      if (ackReq && nextInv != N) ackEarly++;
      if (ackReq && busRdy) ackCyc = cyc;
      if (donePulse) begin doneCnt++; doneCyc = cyc; end
    end
    cyc++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    for (int i = 0; i < N; i++) begin wbCnt[i] = 0; invCnt[i] = 0; end
    nextInv = 0; orderErr = 0; invEarly = 0; stallViol = 0; wbViol = 0;
    ackEarly = 0; doneCnt = 0; doneCyc = 0; ackCyc = 0; startCyc = 0;
    boFired = 0; hdFired = 0; ahFired = 0;
  endtask

  task automatic startFlush();
    clearStats();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && doneCnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkCommon();
    int badInv = 0, badWb = 0;
    for (int i = 0; i < N; i++) begin
      if (invCnt[i] != 1) badInv++;
      if (wbCnt[i] != ((vArr[i] && dArr[i]) ? 1 : 0)) badWb++;
    end
    check(badInv == 0,   "R2 lines without exactly one strobe", badInv, 0);
    check(orderErr == 0, "R2 strobe order", orderErr, 0);
    check(badWb == 0,    "R4 lines with wrong writeback count", badWb, 0);
    check(wbViol == 0,   "R3 writeback on clean line", wbViol, 0);
    check(invEarly == 0, "R4 dirty strobe before bus-ready", invEarly, 0);
    check(stallViol == 0, "R6 request during stall", stallViol, 0);
    check(ackEarly == 0, "R8 ack before last strobe", ackEarly, 0);
    check(doneCnt == 1,  "R9 done count", doneCnt, 1);
    check(doneCyc - ackCyc == 1, "R9 done delay after ack", doneCyc - ackCyc, 1);
    check(busy == 1'b0,  "R10 busy after done", int'(busy), 0);
  endtask

  task automatic setPattern(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: begin vArr[i] = (i % 3 != 0); dArr[i] = (i % 2 == 1); end
        1: begin vArr[i] = 1'b1; dArr[i] = (i % 4 == 0) || (i == N-1); end
        2: begin vArr[i] = 1'b1; dArr[i] = 1'b1; end
        default: begin vArr[i] = (i % 2 == 0); dArr[i] = (i % 2 == 1); end
      endcase
    end
  endtask

  task automatic t_reset();
    check({busy, wbReq, invStrobe, ackReq, donePulse} == 5'b0,
          "R1 reset outputs", int'({busy, wbReq, invStrobe, ackReq, donePulse}), 0);
  endtask

  task automatic t_all_clean();
    setPattern(0);
    for (int i = 0; i < N; i++) dArr[i] = 1'b0;
    rdyWait = 0;
    startFlush();
    waitDone();
    checkCommon();
    check(doneCyc - startCyc == N + 2, "R3 all-clean duration", doneCyc - startCyc, N + 2);
  endtask

  task automatic t_mixed();
    setPattern(0);
    rdyWait = 1;
    startFlush();
    @(negedge clk);
    check(busy == 1'b1, "R10 busy during flush", int'(busy), 1);
    waitDone();
    checkCommon();
  endtask

  task automatic t_invalid_dirty();
    setPattern(3);
    rdyWait = 0;
    startFlush();
    waitDone();
    checkCommon();
  endtask

  task automatic t_backoff();
    setPattern(1);
    rdyWait = 2; boShots = 3;
    startFlush();
    waitDone();
    checkCommon();
    check(boFired == 3, "R5 backoff aborts injected", boFired, 3);
    boShots = 0;
  endtask

  task automatic t_hold();
    setPattern(1);
    rdyWait = 2; hdShots = 2; ahShots = 1;
    startFlush();
    waitDone();
    checkCommon();
    check(hdFired == 2, "R6 holds injected", hdFired, 2);
    check(ahFired == 1, "R6 address hold on ack injected", ahFired, 1);
    hdShots = 0; ahShots = 0;
  endtask

  task automatic t_wbuf();
    setPattern(2);
    rdyWait = 0;
    wbufEmpty = 1'b0;
    startFlush();
    repeat (8) @(negedge clk);
    check(wbCnt[0] == 0 && invCnt[0] == 0, "R7 walk paused on full buffer",
          wbCnt[0] + invCnt[0], 0);
    check(wbReq == 1'b0 && busy == 1'b1, "R7 no request while buffer busy",
          int'({wbReq, busy}), 1);
    wbufEmpty = 1'b1;
    waitDone();
    checkCommon();
  endtask

  task automatic t_restart_ignored();
    setPattern(0);
    rdyWait = 1;
    startFlush();
    repeat (6) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (10) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    waitDone();
    checkCommon();
    repeat (5) @(negedge clk);
    check(doneCnt == 1, "R10 no second completion", doneCnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    setPattern(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_clean();
    t_mixed();
    t_invalid_dirty();
    t_backoff();
    t_hold();
    t_wbuf();
    t_restart_ignored();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule